// File: doc/BRIEF.md
# SPI Command Frame Builder

This block turns one host command into the byte sequence that opens an SPI transaction with a wireless peripheral. The host offers an opcode, a 24-bit address, a 32-bit data word, a 24-bit transfer size and a clockless flag on a valid/ready handshake. The block picks the frame layout for that opcode and latches the bytes. It then streams them one per handshake on a byte-wide transmit port. When CRC is enabled it appends a CRC7 check byte. Response parsing, data payload phases and bit-level shifting belong to neighbouring blocks.

The controller has four states. `ST_IDLE` offers `in_ready`. An accepted legal opcode takes the `IDLE_TO_BODY` transition, and an accepted unknown opcode takes `IDLE_TO_FAULT`. `ST_BODY` emits the opcode and field bytes. After the final body byte it takes `BODY_TO_TAIL` when CRC is on, or `BODY_TO_IDLE` when CRC is off. `ST_TAIL` emits the check byte and takes `TAIL_TO_IDLE`. `ST_FAULT` raises `cmd_err` for exactly one cycle and takes `FAULT_TO_IDLE` without emitting anything.

Top module: `spi_cmd_framer`

## Requirements
- R1: After reset, `in_ready` is 1 and both `tx_valid` and `cmd_err` are 0.
- R2: Opcode 0xCA (single read) produces this body: the opcode, then address bits 23:16, 15:8 and 7:0.
- R3: Opcode 0xC9 (single write) produces this body: the opcode, three address bytes most significant first, then the data word as four bytes, most significant first.
- R4: Opcodes 0xC4 (internal read) and 0xC3 (internal write) start the body with the opcode. Next comes address bits 15:8 with bit 7 forced to 1 when clockless is set, then address bits 7:0. The read then ends with 0x00. The write instead ends with four data bytes, most significant first.
- R5: Opcodes 0xC7 and 0xC8 (extended DMA write and read) produce this body: the opcode, three address bytes, then three size bytes, all most significant first.
- R6: Opcode 0xCF (reset) produces this body: the opcode followed by 0xFF, 0xFF, 0xFF.
- R7: With CRC enabled, one extra byte follows the body. It holds a CRC7 over all body bytes, using polynomial x^7+x^3+1, seed 0x7F and MSB first. The CRC sits in bits 7:1 and bit 0 is 0.
- R8: With `crc_en` low at acceptance, the CRC byte is omitted. The value of `crc_en` is sampled only at acceptance, so later changes do not affect a frame in progress.
- R9: Any other opcode raises `cmd_err` for exactly the one cycle after acceptance. No byte is emitted, and `in_ready` returns the cycle after that.
- R10: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` hold steady.
- R11: `in_ready` stays low from acceptance until the handshake on the byte flagged by `tx_last`. `tx_last` is set on the final byte of a frame and on no other byte. The first byte is valid in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| crc_en | input | 1 | Appends the CRC byte when high; sampled at acceptance |
| in_valid | input | 1 | Command offered |
| in_ready | output | 1 | Command can be accepted |
| in_opcode | input | 8 | Command opcode |
| in_addr | input | 24 | Target address |
| in_data | input | 32 | Write data word |
| in_size | input | 24 | Transfer size for extended DMA commands |
| in_clockless | input | 1 | Sets bit 7 of the internal address high byte |
| tx_valid | output | 1 | Byte available |
| tx_ready | input | 1 | Byte consumer ready |
| tx_data | output | 8 | Frame byte |
| tx_last | output | 1 | Final byte of the frame |
| cmd_err | output | 1 | One-cycle pulse for an unsupported opcode |

## Verification
Two events can fall in the same clock edge: the handshake on the last byte of a frame, and a new command held valid at the input. The bench keeps `in_valid` asserted with a different opcode and a toggling `crc_en` for the whole time a frame streams under random `tx_ready` back-pressure. Every emitted byte is compared with a reference frame, and the reference CRC is computed by polynomial long division. The check passes only if `in_ready` stays low until that final handshake, no held input leaks into the frame in progress, and `in_ready` is high again in the next cycle.

// File: rtl/spi_frm_pkg.sv
package spi_frm_pkg;
    localparam int BYTE_W   = 8;
    localparam int ADDR_W   = 24;
    localparam int DATA_W   = 32;
    localparam int SIZE_W   = 24;
    localparam int CRC_W    = 7;
    localparam int BODY_MAX = 8;
    localparam int IDX_W    = $clog2(BODY_MAX + 1);
    localparam logic [CRC_W-1:0] CRC_SEED = 7'h7F;
    localparam logic [CRC_W-1:0] CRC_POLY = 7'h09;

    localparam logic [BYTE_W-1:0] OP_INT_WR = 8'hC3;
    localparam logic [BYTE_W-1:0] OP_INT_RD = 8'hC4;
    localparam logic [BYTE_W-1:0] OP_EXT_WR = 8'hC7;
    localparam logic [BYTE_W-1:0] OP_EXT_RD = 8'hC8;
    localparam logic [BYTE_W-1:0] OP_SGL_WR = 8'hC9;
    localparam logic [BYTE_W-1:0] OP_SGL_RD = 8'hCA;
    localparam logic [BYTE_W-1:0] OP_RESET  = 8'hCF;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BODY  = 2'd1,
        ST_TAIL  = 2'd2,
        ST_FAULT = 2'd3
    } frm_state_e;
endpackage

// File: rtl/frm_layout.sv
module frm_layout
    import spi_frm_pkg::*;
(
    input  logic [BYTE_W-1:0]               opcode,
    input  logic [ADDR_W-1:0]               addr,
    input  logic [DATA_W-1:0]               data,
    input  logic [SIZE_W-1:0]               size,
    input  logic                            clockless,
    output logic                            legal,
    output logic [IDX_W-1:0]                body_len,
    output logic [BODY_MAX-1:0][BYTE_W-1:0] body
);
    logic [BYTE_W-1:0] int_hi;

    always_comb begin
        int_hi = addr[15:8];
        if (clockless) int_hi[7] = 1'b1;
    end

    always_comb begin
        body     = '0;
        legal    = 1'b1;
        body_len = IDX_W'(4);
        body[0]  = opcode;
        case (opcode)
            OP_SGL_RD: begin
                body[1] = addr[23:16];
                body[2] = addr[15:8];
                body[3] = addr[7:0];
            end
            OP_SGL_WR: begin
                body[1] = addr[23:16];
                body[2] = addr[15:8];
                body[3] = addr[7:0];
                body[4] = data[31:24];
                body[5] = data[23:16];
                body[6] = data[15:8];
                body[7] = data[7:0];
                body_len = IDX_W'(8);
            end
            OP_INT_RD: begin
                body[1] = int_hi;
                body[2] = addr[7:0];
                body[3] = 8'h00;
            end
            OP_INT_WR: begin
                body[1] = int_hi;
                body[2] = addr[7:0];
                body[3] = data[31:24];
                body[4] = data[23:16];
                body[5] = data[15:8];
                body[6] = data[7:0];
                body_len = IDX_W'(7);
            end
            OP_EXT_WR, OP_EXT_RD: begin
                body[1] = addr[23:16];
                body[2] = addr[15:8];
                body[3] = addr[7:0];
                body[4] = size[23:16];
                body[5] = size[15:8];
                body[6] = size[7:0];
                body_len = IDX_W'(7);
            end
            OP_RESET: begin
                body[1] = 8'hFF;
                body[2] = 8'hFF;
                body[3] = 8'hFF;
            end
            default: begin
                legal    = 1'b0;
                body_len = '0;
            end
        endcase
    end
endmodule

// File: rtl/crc7_step.sv
module crc7_step
    import spi_frm_pkg::*;
(
    input  logic [CRC_W-1:0]  crc_in,
    input  logic [BYTE_W-1:0] byte_in,
    output logic [CRC_W-1:0]  crc_out
);
    logic [CRC_W-1:0] acc;
    logic             fb;

    always_comb begin
        acc = crc_in;
        fb  = 1'b0;
        for (int b = BYTE_W - 1; b >= 0; b--) begin
            fb  = acc[CRC_W-1] ^ byte_in[b];
            acc = {acc[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
        end
        crc_out = acc;
    end
endmodule

// File: rtl/spi_cmd_framer.sv
module spi_cmd_framer
    import spi_frm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              crc_en,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [7:0]        in_opcode,
    input  logic [23:0]       in_addr,
    input  logic [31:0]       in_data,
    input  logic [23:0]       in_size,
    input  logic              in_clockless,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [7:0]        tx_data,
    output logic              tx_last,
    output logic              cmd_err
);
    frm_state_e state_q, state_d;

    logic [BODY_MAX-1:0][BYTE_W-1:0] frame_q;
    logic [BODY_MAX-1:0][BYTE_W-1:0] lay_body;
    logic [IDX_W-1:0]                len_q, idx_q, lay_len;
    logic [CRC_W-1:0]                crc_q, crc_nx;
    logic                            crc_on_q;
    logic                            lay_legal;
    logic                            accept, at_end, beat;
    logic [BYTE_W-1:0]               cur_byte;

    frm_layout u_layout (
        .opcode    (in_opcode),
        .addr      (in_addr),
        .data      (in_data),
        .size      (in_size),
        .clockless (in_clockless),
        .legal     (lay_legal),
        .body_len  (lay_len),
        .body      (lay_body)
    );

    assign cur_byte = frame_q[idx_q[$clog2(BODY_MAX)-1:0]];

    crc7_step u_crc (
        .crc_in  (crc_q),
        .byte_in (cur_byte),
        .crc_out (crc_nx)
    );

    assign accept = (state_q == ST_IDLE) && in_valid;
    assign at_end = (idx_q == len_q - IDX_W'(1));
    assign beat   = (state_q == ST_BODY) && tx_ready;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (in_valid) state_d = lay_legal ? ST_BODY : ST_FAULT;
            ST_BODY:  if (tx_ready && at_end) state_d = crc_on_q ? ST_TAIL : ST_IDLE;
            ST_TAIL:  if (tx_ready) state_d = ST_IDLE;
            ST_FAULT: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        in_ready = 1'b0;
        tx_valid = 1'b0;
        tx_data  = '0;
        tx_last  = 1'b0;
        cmd_err  = 1'b0;
        unique case (state_q)
            ST_IDLE:  in_ready = 1'b1;
            ST_BODY: begin
                tx_valid = 1'b1;
                tx_data  = cur_byte;
                tx_last  = at_end && !crc_on_q;
            end
            ST_TAIL: begin
                tx_valid = 1'b1;
                tx_data  = {crc_q, 1'b0};
                tx_last  = 1'b1;
            end
            ST_FAULT: cmd_err = 1'b1;
        endcase
    end

    // frame datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_q  <= '0;
            len_q    <= '0;
            idx_q    <= '0;
            crc_q    <= CRC_SEED;
            crc_on_q <= 1'b0;
        end else if (accept) begin
            frame_q  <= lay_body;
            len_q    <= lay_len;
            idx_q    <= '0;
            crc_q    <= CRC_SEED;
            crc_on_q <= crc_en;
        end else if (beat) begin
            idx_q <= idx_q + IDX_W'(1);
            crc_q <= crc_nx;
        end
    end
endmodule

// File: rtl/spi_cmd_framer_chk.sv
module spi_cmd_framer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       crc_en,
    input logic       in_valid,
    input logic       in_ready,
    input logic [7:0] in_opcode,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic [7:0] tx_data,
    input logic       tx_last,
    input logic       cmd_err
);
    logic [3:0] beats_q;
    logic       crc_seen_q;
    logic       legal_op;

    assign legal_op = (in_opcode == 8'hC3) || (in_opcode == 8'hC4) ||
                      (in_opcode == 8'hC7) || (in_opcode == 8'hC8) ||
                      (in_opcode == 8'hC9) || (in_opcode == 8'hCA) ||
                      (in_opcode == 8'hCF);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beats_q    <= '0;
            crc_seen_q <= 1'b0;
        end else begin
            if (in_valid && in_ready) crc_seen_q <= crc_en;
            if (tx_valid && tx_ready) beats_q <= tx_last ? 4'd0 : beats_q + 4'd1;
        end
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> !tx_valid);                                               // R11
    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last)); // R10
    AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |=> !cmd_err && in_ready);                                     // R9
    AST_ERR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |-> !tx_valid);                                                // R9
    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && !legal_op |=> cmd_err);                        // R9
    AST_FIRST_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && legal_op |=> tx_valid && tx_data == $past(in_opcode)); // R11
    AST_CRC_LSB: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && tx_last && crc_seen_q |-> !tx_data[0]);                    // R7
    AST_FRAME_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && tx_ready && tx_last |-> beats_q >= 4'd3 && beats_q <= 4'd8); // R8
endmodule

bind spi_cmd_framer spi_cmd_framer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .crc_en    (crc_en),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_opcode (in_opcode),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .tx_data   (tx_data),
    .tx_last   (tx_last),
    .cmd_err   (cmd_err)
);

// File: tb/spi_cmd_framer_tb_top.sv
`timescale 1ns/1ps
module spi_cmd_framer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        crc_en = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_opcode = 8'h00;
    logic [23:0] in_addr = '0;
    logic [31:0] in_data = '0;
    logic [23:0] in_size = '0;
    logic        in_clockless = 1'b0;
    logic        tx_valid;
    logic        tx_ready = 1'b0;
    logic [7:0]  tx_data;
    logic        tx_last;
    logic        cmd_err;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit finished = 0;

    logic [7:0] exp_b [0:9];
    int         exp_n;
    bit         exp_legal;

    always #2 clk = ~clk;

    spi_cmd_framer dut_i (
        .clk(clk), .rst_n(rst_n), .crc_en(crc_en),
        .in_valid(in_valid), .in_ready(in_ready), .in_opcode(in_opcode),
        .in_addr(in_addr), .in_data(in_data), .in_size(in_size),
        .in_clockless(in_clockless), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_data(tx_data), .tx_last(tx_last), .cmd_err(cmd_err)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
        end
    endtask

    // remainder of v(x)*x^7 divided by x^7+x^3+1
    function automatic logic [6:0] crc_fold(input logic [6:0] crc, input logic [7:0] b);
        logic [14:0] r;
        r = {((({1'b0, crc} << 1) ^ {1'b0, b})) , 7'b0};
        for (int k = 14; k >= 7; k--)
            if (r[k]) r = r ^ (15'h89 << (k - 7));
        return r[6:0];
    endfunction

    function automatic string req_of(input logic [7:0] op);
        case (op)
            8'hCA: return "R2";
            8'hC9: return "R3";
            8'hC3, 8'hC4: return "R4";
            8'hC7, 8'hC8: return "R5";
            8'hCF: return "R6";
            default: return "R9";
        endcase
    endfunction

    function automatic bit is_legal(input logic [7:0] op);
        return op == 8'hC3 || op == 8'hC4 || op == 8'hC7 || op == 8'hC8 ||
               op == 8'hC9 || op == 8'hCA || op == 8'hCF;
    endfunction

    task automatic build_exp(input logic [7:0] op, input logic [23:0] a, input logic [31:0] d,
                             input logic [23:0] s, input bit cl, input bit ce);
        logic [6:0] c;
        logic [7:0] hi;
        exp_legal = is_legal(op);
        exp_b[0] = op;
        hi = a[15:8] | (cl ? 8'h80 : 8'h00);
        exp_n = 4;
        case (op)
            8'hCA: begin exp_b[1]=a[23:16]; exp_b[2]=a[15:8]; exp_b[3]=a[7:0]; end
            8'hC9: begin exp_b[1]=a[23:16]; exp_b[2]=a[15:8]; exp_b[3]=a[7:0];
                         exp_b[4]=d[31:24]; exp_b[5]=d[23:16]; exp_b[6]=d[15:8]; exp_b[7]=d[7:0]; exp_n=8; end
            8'hC4: begin exp_b[1]=hi; exp_b[2]=a[7:0]; exp_b[3]=8'h00; end
            8'hC3: begin exp_b[1]=hi; exp_b[2]=a[7:0]; exp_b[3]=d[31:24];
                         exp_b[4]=d[23:16]; exp_b[5]=d[15:8]; exp_b[6]=d[7:0]; exp_n=7; end
            8'hC7, 8'hC8: begin exp_b[1]=a[23:16]; exp_b[2]=a[15:8]; exp_b[3]=a[7:0];
                         exp_b[4]=s[23:16]; exp_b[5]=s[15:8]; exp_b[6]=s[7:0]; exp_n=7; end
            8'hCF: begin exp_b[1]=8'hFF; exp_b[2]=8'hFF; exp_b[3]=8'hFF; end
            default: exp_n = 0;
        endcase
        if (exp_legal && ce) begin
            c = 7'h7F;
            for (int i = 0; i < exp_n; i++) c = crc_fold(c, exp_b[i]);
            exp_b[exp_n] = {c, 1'b0};
            exp_n++;
        end
    endtask

    task automatic run_frame(input logic [7:0] op, input logic [23:0] a, input logic [31:0] d,
                             input logic [23:0] s, input bit cl, input bit ce, input int rdy_pct);
        int n = 0;
        int guard = 0;
        bit stall = 0;
        bit done = 0;
        logic [7:0] pd = '0;
        logic pl = 1'b0;
        string rq;
        build_exp(op, a, d, s, cl, ce);
        rq = req_of(op);
        chk(in_ready == 1'b1, "R11", "in_ready before offer", in_ready, 1);
        in_opcode = op; in_addr = a; in_data = d; in_size = s;
        in_clockless = cl; crc_en = ce; in_valid = 1'b1;
        @(posedge clk); @(negedge clk);
        // hold a different command valid while busy
        in_opcode = 8'h00; in_addr = $urandom; in_data = $urandom;
        in_size = $urandom; in_clockless = ~cl; crc_en = ~ce;
        if (!exp_legal) begin
            chk(cmd_err == 1'b1, "R9", "cmd_err after bad opcode", cmd_err, 1);
            chk(tx_valid == 1'b0, "R9", "no byte for bad opcode", tx_valid, 0);
            @(negedge clk);
            chk(cmd_err == 1'b0, "R9", "cmd_err single cycle", cmd_err, 0);
            chk(in_ready == 1'b1 && tx_valid == 1'b0, "R9", "back to idle", in_ready, 1);
            in_valid = 1'b0;
            return;
        end
        chk(tx_valid == 1'b1, "R11", "first byte next cycle", tx_valid, 1);
        while (!done) begin
            tx_ready = ($urandom % 100) < rdy_pct;
            crc_en = $urandom;
            if (stall)
                chk(tx_valid && tx_data == pd && tx_last == pl, "R10", "stall hold", tx_data, pd);
            chk(in_ready == 1'b0, "R11", "in_ready low while busy", in_ready, 0);
            if (tx_valid && tx_ready) begin
                if (ce && n == exp_n - 1)
                    chk(tx_data == exp_b[n], "R7", "crc byte", tx_data, exp_b[n]);
                else
                    chk(tx_data == exp_b[n], rq, $sformatf("byte %0d", n), tx_data, exp_b[n]);
                chk(tx_last == (n == exp_n - 1), "R11", "tx_last position", tx_last, (n == exp_n - 1));
                n++;
                if (n >= exp_n) done = 1;
            end
            stall = tx_valid && !tx_ready;
            pd = tx_data; pl = tx_last;
            @(posedge clk); @(negedge clk);
            guard++;
            if (guard > 200) begin
                chk(1'b0, "R11", "frame never ended", n, exp_n);
                done = 1;
            end
        end
        tx_ready = 1'b0;
        chk(in_ready == 1'b1 && tx_valid == 1'b0, "R11", "idle after last byte", in_ready, 1);
        chk(n == exp_n, "R8", "frame length", n, exp_n);
        in_valid = 1'b0;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000 && !finished) begin
                n_checks++; n_fail++;
                $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
                $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
                $finish;
            end
        end
    end

    initial begin
        logic [7:0] ops [7];
        logic [7:0] op;
        void'($urandom(32'd4711));
        ops[0]=8'hC3; ops[1]=8'hC4; ops[2]=8'hC7; ops[3]=8'hC8;
        ops[4]=8'hC9; ops[5]=8'hCA; ops[6]=8'hCF;
        repeat (3) @(negedge clk);
        chk(in_ready == 1'b1, "R1", "in_ready in reset", in_ready, 1);
        chk(tx_valid == 1'b0 && cmd_err == 1'b0, "R1", "outputs quiet in reset", tx_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b1 && tx_valid == 1'b0 && cmd_err == 1'b0, "R1", "idle after reset", in_ready, 1);

        // directed corner cases
        run_frame(8'hCA, 24'h123456, 32'h0, 24'h0, 1'b0, 1'b1, 100);  // R2
        run_frame(8'hC9, 24'hABCDEF, 32'hDEADBEEF, 24'h0, 1'b0, 1'b1, 50); // R3
        run_frame(8'hC4, 24'h00E824, 32'h0, 24'h0, 1'b1, 1'b1, 100);  // R4 clockless
        run_frame(8'hC4, 24'h00E824, 32'h0, 24'h0, 1'b0, 1'b0, 100);  // R4 no crc
        run_frame(8'hC3, 24'h0000FF, 32'h01020304, 24'h0, 1'b1, 1'b1, 30); // R4
        run_frame(8'hC7, 24'h010203, 32'h0, 24'hFFFFFF, 1'b0, 1'b1, 100); // R5
        run_frame(8'hC8, 24'hFFFFFF, 32'h0, 24'h000002, 1'b0, 1'b0, 20);  // R5 R8
        run_frame(8'hCF, 24'h0, 32'h0, 24'h0, 1'b0, 1'b1, 100);  // R6 R7
        run_frame(8'hCF, 24'h0, 32'h0, 24'h0, 1'b0, 1'b0, 100);  // R6 R8
        run_frame(8'h00, 24'h0, 32'h0, 24'h0, 1'b0, 1'b1, 100);  // R9
        run_frame(8'hC5, 24'h0, 32'h0, 24'h0, 1'b0, 1'b1, 100);  // R9
        run_frame(8'hCA, 24'h000000, 32'h0, 24'h0, 1'b0, 1'b1, 10); // R10 heavy stall

        // constrained random
        for (int k = 0; k < 300; k++) begin
            if (($urandom % 8) == 0) begin
                op = $urandom;
                if (is_legal(op)) op = 8'hD0;
            end else begin
                op = ops[$urandom % 7];
            end
            run_frame(op, $urandom, $urandom, $urandom, $urandom, $urandom, 20 + ($urandom % 81));
            if (($urandom % 3) == 0) @(negedge clk);
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule